// File: doc/BRIEF.md
# Per-Wavefront Lost-Locality Detector

This block sits beside an L1 data cache. Each cache line remembers which wavefront allocated it. When such a line is evicted, the cache hands its tag and owner ID to this detector. The detector stores the tag in a small set of victim tags kept only for that owner.

When the same wavefront later misses in the L1, the cache probes the detector with the requester's ID and the line tag. If the tag is found among that wavefront's own victim tags, the wavefront had the line and lost it before reusing it. The detector then raises a one-cycle event carrying the wavefront ID, which a scheduler can use to throttle that wavefront. No data is kept; only tags and valid bits.

Tags are the address bits above the 128-byte line offset, that is bits 31 and down to bit 7 of a 32-bit address. This gives a default tag width of 25 bits. There are 32 wavefronts with 8 victim entries each.

Top module: `vtag_loss_detector`

## Requirements
- R1: While `rst_n` is low every victim entry becomes invalid and `lost_vld` is 0. A probe after reset produces no event even for a tag evicted before the reset.
- R2: After an eviction of tag T for wavefront W, a probe of (W, T) raises `lost_vld` with `lost_wid` equal to W. This holds for every W from 0 to 31.
- R3: Victim tags are private to a wavefront. A probe with a different wavefront ID, or with the same ID and a different tag, raises no event.
- R4: `lost_vld` is registered. It is high in the cycle after the edge that sampled a hitting probe, and low in every cycle that follows no probe.
- R5: A probe hit invalidates the matching entry, so a repeated probe of the same pair with no new eviction raises no event.
- R6: Each wavefront keeps its 8 most recent victim tags in FIFO order. The 9th eviction to a wavefront overwrites the oldest entry, and the other 8 stay found.
- R7: When a probe and an eviction arrive in the same cycle, the probe sees the state from before that eviction. The tag being evicted is therefore not found by the probe in that cycle, but it is found by a later probe.
- R8: A probe hit and an eviction may land on the same entry in the same cycle. In that case the event is raised and the newly evicted tag is stored valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits |
| evict_vld | input | 1 | An L1 line is being evicted this cycle |
| evict_wid | input | 5 | Wavefront ID stored with the evicted line |
| evict_tag | input | 25 | Tag of the evicted line |
| probe_vld | input | 1 | An L1 miss probes the detector this cycle |
| probe_wid | input | 5 | Wavefront ID of the missing request |
| probe_tag | input | 25 | Tag of the missing request |
| lost_vld | output | 1 | Lost-locality event, one cycle after the hitting probe |
| lost_wid | output | 5 | Wavefront ID of the event |

## Verification
The bench probes with a tag that another wavefront evicted. A detector that shared victim storage across wavefronts would report a false event there. It fills one wavefront with nine evictions to catch a pointer that fails to wrap or that keeps the oldest tag. It also repeats a hitting probe to catch a design that never invalidates and so reports one eviction many times. Same-cycle probe and eviction cases check that the probe reads the old state and that an eviction landing on a just-hit entry is not lost to the invalidation.

// File: rtl/vtag_loss_detector.sv
module vtag_loss_detector #(
  parameter int NUM_WAVES = 32,
  parameter int WAYS      = 8,
  parameter int TAG_W     = 25,
  localparam int WID_W    = $clog2(NUM_WAVES),
  localparam int PTR_W    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evict_vld,
  input  logic [WID_W-1:0] evict_wid,
  input  logic [TAG_W-1:0] evict_tag,
  input  logic             probe_vld,
  input  logic [WID_W-1:0] probe_wid,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             lost_vld,
  output logic [WID_W-1:0] lost_wid
);

  logic [TAG_W-1:0] tag_q [NUM_WAVES][WAYS];
  logic [WAYS-1:0]  vld_q [NUM_WAVES];
  logic [PTR_W-1:0] ptr_q [NUM_WAVES];
  logic [WAYS-1:0]  hit_vec;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] nxt_ptr;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = probe_vld && vld_q[probe_wid][w] && (tag_q[probe_wid][w] == probe_tag);
  end

  assign wr_ptr  = ptr_q[evict_wid];
  assign nxt_ptr = (wr_ptr == PTR_W'(WAYS - 1)) ? '0 : wr_ptr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (evict_vld) tag_q[evict_wid][wr_ptr] <= evict_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_WAVES; g++) begin
        vld_q[g] <= '0;
        ptr_q[g] <= '0;
      end
      lost_vld <= 1'b0;
      lost_wid <= '0;
    end else begin
      if (probe_vld) vld_q[probe_wid] <= vld_q[probe_wid] & ~hit_vec;
      if (evict_vld) begin
        vld_q[evict_wid][wr_ptr] <= 1'b1;
        ptr_q[evict_wid]         <= nxt_ptr;
      end
      lost_vld <= |hit_vec;
      if (probe_vld) lost_wid <= probe_wid;
    end
  end

endmodule

// File: rtl/vtag_loss_detector_chk.sv
module vtag_loss_detector_chk #(
  parameter int WID_W = 5,
  parameter int TAG_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evict_vld,
  input logic             probe_vld,
  input logic [WID_W-1:0] probe_wid,
  input logic [TAG_W-1:0] probe_tag,
  input logic             lost_vld,
  input logic [WID_W-1:0] lost_wid
);

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !lost_vld);

  assert_event_wid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lost_vld |-> lost_wid == $past(probe_wid));

  assert_event_needs_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lost_vld |-> $past(probe_vld));

  assert_single_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_vld && probe_vld && probe_wid == $past(probe_wid) &&
     probe_tag == $past(probe_tag) && !$past(evict_vld)) |=> !lost_vld);

endmodule

bind vtag_loss_detector vtag_loss_detector_chk #(.WID_W(WID_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evict_vld(evict_vld), .probe_vld(probe_vld),
  .probe_wid(probe_wid), .probe_tag(probe_tag), .lost_vld(lost_vld), .lost_wid(lost_wid)
);

// File: tb/vtag_loss_detector_tb.sv
module vtag_loss_detector_tb_top;
  localparam int WID_W = 5;
  localparam int TAG_W = 25;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             evict_vld = 1'b0;
  logic [WID_W-1:0] evict_wid = '0;
  logic [TAG_W-1:0] evict_tag = '0;
  logic             probe_vld = 1'b0;
  logic [WID_W-1:0] probe_wid = '0;
  logic [TAG_W-1:0] probe_tag = '0;
  logic             lost_vld;
  logic [WID_W-1:0] lost_wid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic             obs_vld;
  logic [WID_W-1:0] obs_wid;

  always #5 clk = ~clk;

  vtag_loss_detector dut_i (
    .clk(clk), .rst_n(rst_n),
    .evict_vld(evict_vld), .evict_wid(evict_wid), .evict_tag(evict_tag),
    .probe_vld(probe_vld), .probe_wid(probe_wid), .probe_tag(probe_tag),
    .lost_vld(lost_vld), .lost_wid(lost_wid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit ev, input int ew, input int et,
                      input bit pv, input int pw, input int pt);
    @(negedge clk);
    evict_vld = ev; evict_wid = WID_W'(ew); evict_tag = TAG_W'(et);
    probe_vld = pv; probe_wid = WID_W'(pw); probe_tag = TAG_W'(pt);
    @(posedge clk);
    #1;
    obs_vld = lost_vld;
    obs_wid = lost_wid;
    evict_vld = 1'b0;
    probe_vld = 1'b0;
  endtask

  task automatic evict(input int w, input int t);
    step(1, w, t, 0, 0, 0);
  endtask

  task automatic expect_probe(input int w, input int t, input bit hit, input string req);
    step(0, 0, 0, 1, w, t);
    check(obs_vld == hit, req, obs_vld, hit);
    if (hit) check(obs_wid == WID_W'(w), req, obs_wid, w);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_R1();
    do_reset();
    check(lost_vld == 1'b0, "R1", lost_vld, 0);
    expect_probe(0, 5, 0, "R1");
    evict(3, 7);
    do_reset();
    expect_probe(3, 7, 0, "R1");
  endtask

  task automatic t_basic_R2_R4();
    evict(4, 'h100);
    step(0, 0, 0, 0, 0, 0);
    check(obs_vld == 1'b0, "R4", obs_vld, 0);
    expect_probe(4, 'h100, 1, "R2");
    step(0, 0, 0, 0, 0, 0);
    check(obs_vld == 1'b0, "R4", obs_vld, 0);
    evict(31, 'h1FF_FFFF);
    expect_probe(31, 'h1FF_FFFF, 1, "R2");
  endtask

  task automatic t_isolate_R3();
    evict(7, 'hA5);
    expect_probe(8, 'hA5, 0, "R3");
    expect_probe(7, 'hA6, 0, "R3");
    expect_probe(7, 'hA5, 1, "R3");
  endtask

  task automatic t_once_R5();
    evict(9, 'hC0);
    expect_probe(9, 'hC0, 1, "R5");
    expect_probe(9, 'hC0, 0, "R5");
  endtask

  task automatic t_fifo_R6();
    for (int i = 0; i < 9; i++) evict(12, 'h200 + i);
    expect_probe(12, 'h200, 0, "R6");
    for (int i = 1; i < 9; i++) expect_probe(12, 'h200 + i, 1, "R6");
  endtask

  task automatic t_same_cycle_R7();
    step(1, 15, 'hD0, 1, 15, 'hD0);
    check(obs_vld == 1'b0, "R7", obs_vld, 0);
    expect_probe(15, 'hD0, 1, "R7");
  endtask

  task automatic t_collide_R8();
    for (int i = 0; i < 8; i++) evict(20, 'h300 + i);
    step(1, 20, 'h3FF, 1, 20, 'h300);
    check(obs_vld == 1'b1, "R8", obs_vld, 1);
    check(obs_wid == WID_W'(20), "R8", obs_wid, 20);
    expect_probe(20, 'h3FF, 1, "R8");
    expect_probe(20, 'h301, 1, "R8");
  endtask

  initial begin
    t_reset_R1();
    t_basic_R2_R4();
    t_isolate_R3();
    t_once_R5();
    t_fifo_R6();
    t_same_cycle_R7();
    t_collide_R8();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule